// File: doc/BRIEF.md
# Accumulator Load/Store Banked Memory

This block is a small memory subsystem that serves a single accumulator. Commands arrive as a load or store with a word address. Each command is carried out over several clock cycles through an address holding register and a data holding register, and a one-cycle completion pulse marks the end. A load copies the addressed word into the accumulator. A store copies the accumulator into the addressed word.

The storage is split into equal banks. The upper address bits go through a decoder that raises one chip enable per bank. The lower address bits reach every bank in parallel, and only the enabled bank acts on them. With the default parameters the store holds 4096 words of 16 bits in four banks of 1024 words. Bank 0 holds the lowest addresses, and each following bank holds the next range in order.

The command port uses a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command is taken on a rising edge where both `cmd_valid` and `cmd_ready` are high. While a transfer runs, `cmd_ready` stays low and anything held on the command pins has no effect. A separate plain port lets the surrounding datapath place a value in the accumulator while the block is idle.

Top module: `acc_mem_sys`

## Requirements
- R1: After reset the accumulator reads 0, `cmd_ready` is 1, every `bank_ce` bit is 0 and `done` is 0.
- R2: A command is accepted only on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the cycle after acceptance until the cycle after `done`. While idle with `cmd_valid` low, the outputs do not change.
- R3: While a transfer is in progress (`cmd_ready` is 0), a command on the command pins or an accumulator write request has no effect on the accumulator or on memory.
- R4: The bank chip enable is asserted in the second cycle after acceptance. Only bit `cmd_addr[ADDR_W-1 -: SEL_W]` of `bank_ce` is set, so bank index k serves word addresses k*2^(ADDR_W-SEL_W) through (k+1)*2^(ADDR_W-SEL_W)-1.
- R5: At most one `bank_ce` bit is 1 in any cycle, and all bits are 0 in every cycle other than the access cycle.
- R6: For a load (`cmd_store`=0), `done` is 1 in the fourth cycle after acceptance. In the next cycle the accumulator holds the word stored at the address.
- R7: For a store (`cmd_store`=1), the accumulator value is written to the addressed word, and the accumulator keeps its value. `done` is 1 in the fourth cycle after acceptance.
- R8: `done` is 1 for exactly one cycle per command, and `cmd_ready` returns to 1 in the cycle that follows it.
- R9: When `acc_set_en` is 1 on an edge where `cmd_ready` is 1, the accumulator takes `acc_set_data`. A store accepted on that same edge writes the new value.
- R10: Words on either side of a bank boundary, and the highest address, are stored and returned independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when idle and able to take a command |
| cmd_store | input | 1 | 1 selects store, 0 selects load |
| cmd_addr | input | ADDR_W | Word address of the command |
| acc_set_en | input | 1 | Write `acc_set_data` into the accumulator (idle only) |
| acc_set_data | input | DATA_W | Value for the accumulator write |
| acc_value | output | DATA_W | Current accumulator contents |
| bank_ce | output | 2**SEL_W | One chip enable per bank |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with an 8-bit address, two bank-select bits and 16-bit words. This gives 256 words in four banks of 64, small enough to store a distinct computed pattern to every word and load every word back. Every bank is crossed, every boundary lies inside the sweep, and the decoded enable is checked against each address's upper bits. Further directed sequences drive commands and accumulator writes during a transfer and check that they change neither the accumulator nor the target word.

// File: rtl/acc_mem_pkg.sv
package acc_mem_pkg;

  typedef enum logic [2:0] {
    XS_IDLE   = 3'd0,
    XS_ADDR   = 3'd1,
    XS_ACCESS = 3'd2,
    XS_XFER   = 3'd3,
    XS_DONE   = 3'd4
  } xfer_state_t;

  typedef enum logic {
    XOP_LOAD  = 1'b0,
    XOP_STORE = 1'b1
  } xfer_op_t;

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int SEL_W = 2,
  localparam int NUM_BANKS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic                 enable,
  output logic [NUM_BANKS-1:0] ce
);

  // one comparator per bank output
  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_ce
    assign ce[gi] = enable && (sel == SEL_W'(gi));
  end

endmodule

// File: rtl/mem_bank.sv
module mem_bank #(
  parameter int DATA_W = 16,
  parameter int LOC_W  = 10,
  localparam int DEPTH = 1 << LOC_W
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              we,
  input  logic [LOC_W-1:0]  loc_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  // synchronous single port: read data appears the cycle after ce
  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) begin
        cells[loc_addr] <= wdata;
      end else begin
        rdata <= cells[loc_addr];
      end
    end
  end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import acc_mem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_store,
  output logic cmd_ready,
  output logic accept,
  output logic mbr_from_acc,
  output logic bank_access,
  output logic bank_we,
  output logic mbr_from_mem,
  output logic acc_from_mbr,
  output logic done
);

  xfer_state_t state_q, state_d;
  xfer_op_t    op_q;

  assign cmd_ready = (state_q == XS_IDLE);
  assign accept    = cmd_ready && cmd_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE:   if (accept) state_d = XS_ADDR;
      XS_ADDR:   state_d = XS_ACCESS;
      XS_ACCESS: state_d = XS_XFER;
      XS_XFER:   state_d = XS_DONE;
      XS_DONE:   state_d = XS_IDLE;
      default:   state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      op_q    <= XOP_LOAD;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q <= cmd_store ? XOP_STORE : XOP_LOAD;
      end
    end
  end

  // datapath strobes, one per step of the transfer
  assign mbr_from_acc = (state_q == XS_ADDR)   && (op_q == XOP_STORE);
  assign bank_access  = (state_q == XS_ACCESS);
  assign bank_we      = (state_q == XS_ACCESS) && (op_q == XOP_STORE);
  assign mbr_from_mem = (state_q == XS_XFER)   && (op_q == XOP_LOAD);
  assign acc_from_mbr = (state_q == XS_DONE)   && (op_q == XOP_LOAD);
  assign done         = (state_q == XS_DONE);

endmodule

// File: rtl/acc_mem_sys.sv
module acc_mem_sys #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 2,
  localparam int NUM_BANKS = 1 << SEL_W,
  localparam int LOC_W     = ADDR_W - SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_store,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic                 acc_set_en,
  input  logic [DATA_W-1:0]    acc_set_data,
  output logic [DATA_W-1:0]    acc_value,
  output logic [NUM_BANKS-1:0] bank_ce,
  output logic                 done
);

  logic accept, mbr_from_acc, bank_access, bank_we, mbr_from_mem, acc_from_mbr;

  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q;
  logic [DATA_W-1:0] acc_q;

  logic [SEL_W-1:0]  bank_sel;
  logic [LOC_W-1:0]  loc_addr;
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];

  xfer_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_store    (cmd_store),
    .cmd_ready    (cmd_ready),
    .accept       (accept),
    .mbr_from_acc (mbr_from_acc),
    .bank_access  (bank_access),
    .bank_we      (bank_we),
    .mbr_from_mem (mbr_from_mem),
    .acc_from_mbr (acc_from_mbr),
    .done         (done)
  );

  // address register: captured on acceptance, drives the address bus
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q <= '0;
    end else if (accept) begin
      mar_q <= cmd_addr;
    end
  end

  assign bank_sel = mar_q[ADDR_W-1 -: SEL_W];
  assign loc_addr = mar_q[LOC_W-1:0];

  // data register: from accumulator on store, from the bank on load
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbr_q <= '0;
    end else if (mbr_from_acc) begin
      mbr_q <= acc_q;
    end else if (mbr_from_mem) begin
      mbr_q <= bank_rdata[bank_sel];
    end
  end

  // accumulator: loaded from the data register or from the side port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_from_mbr) begin
      acc_q <= mbr_q;
    end else if (acc_set_en && cmd_ready) begin
      acc_q <= acc_set_data;
    end
  end

  assign acc_value = acc_q;

  bank_decoder #(.SEL_W(SEL_W)) u_dec (
    .sel    (bank_sel),
    .enable (bank_access),
    .ce     (bank_ce)
  );

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    mem_bank #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_bank (
      .clk      (clk),
      .ce       (bank_ce[gb]),
      .we       (bank_we),
      .loc_addr (loc_addr),
      .wdata    (mbr_q),
      .rdata    (bank_rdata[gb])
    );
  end

endmodule

// File: rtl/acc_mem_sys_chk.sv
module acc_mem_sys_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 2,
  localparam int NUM_BANKS = 1 << SEL_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [ADDR_W-1:0]    cmd_addr,
  input logic [DATA_W-1:0]    acc_value,
  input logic [NUM_BANKS-1:0] bank_ce,
  input logic                 done
);

  localparam logic [NUM_BANKS-1:0] ONE_HOT0 = NUM_BANKS'(1);

  // R5
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_ce));

  // R5
  ce_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bank_ce == '0));

  // R4
  ce_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> ##2
      (bank_ce == (ONE_HOT0 << $past(cmd_addr[ADDR_W-1 -: SEL_W], 2))));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  // R3
  acc_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !done) |=> $stable(acc_value));

endmodule

bind acc_mem_sys acc_mem_sys_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .acc_value (acc_value),
  .bank_ce   (bank_ce),
  .done      (done)
);

// File: tb/acc_mem_sys_tb_top.sv
module acc_mem_sys_tb_top;

  localparam int DW = 16;
  localparam int AW = 8;
  localparam int SW = 2;
  localparam int NB = 1 << SW;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_store = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          acc_set_en = 1'b0;
  logic [DW-1:0] acc_set_data = '0;
  logic [DW-1:0] acc_value;
  logic [NB-1:0] bank_ce;
  logic          done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  acc_mem_sys #(.DATA_W(DW), .ADDR_W(AW), .SEL_W(SW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_store    (cmd_store),
    .cmd_addr     (cmd_addr),
    .acc_set_en   (acc_set_en),
    .acc_set_data (acc_set_data),
    .acc_value    (acc_value),
    .bank_ce      (bank_ce),
    .done         (done)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 40503 + 4660) ^ (a << 9));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_acc(input logic [DW-1:0] v);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 ready before set", 32'(cmd_ready), 32'd1);
    acc_set_en = 1'b1;
    acc_set_data = v;
    @(negedge clk);
    acc_set_en = 1'b0;
    chk(acc_value == v, "R9 accumulator write", 32'(acc_value), 32'(v));
  endtask

  // one command; when inject is set, a store and an accumulator write are
  // held on the pins during the busy cycles
  task automatic run_cmd(input bit st, input int a, input bit inject,
                         input logic [DW-1:0] acc_exp);
    logic [NB-1:0] ce_exp;
    ce_exp = NB'(1) << (a >> (AW - SW));
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R2 ready when idle", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1;
    cmd_store = st;
    cmd_addr  = AW'(a);
    @(negedge clk);                          // address cycle
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2 busy after accept", 32'(cmd_ready), 32'd0);
    chk(bank_ce == '0, "R5 no enable before access", 32'(bank_ce), 32'd0);
    if (inject) begin
      cmd_valid = 1'b1;
      cmd_store = 1'b1;
      cmd_addr  = AW'(a ^ 8'hC3);
      acc_set_en = 1'b1;
      acc_set_data = 16'hDEAD;
    end
    @(negedge clk);                          // access cycle
    chk(bank_ce == ce_exp, "R4 decoded bank enable", 32'(bank_ce), 32'(ce_exp));
    @(negedge clk);                          // transfer cycle
    chk(bank_ce == '0, "R5 enable off after access", 32'(bank_ce), 32'd0);
    chk(done == 1'b0, "R8 no early done", 32'(done), 32'd0);
    @(negedge clk);                          // done cycle
    cmd_valid = 1'b0;
    acc_set_en = 1'b0;
    chk(done == 1'b1, st ? "R7 store done" : "R6 load done", 32'(done), 32'd1);
    chk(cmd_ready == 1'b0, "R3 still busy at done", 32'(cmd_ready), 32'd0);
    @(negedge clk);                          // back to idle
    chk(done == 1'b0, "R8 done one cycle", 32'(done), 32'd0);
    chk(cmd_ready == 1'b1, "R8 ready after done", 32'(cmd_ready), 32'd1);
    chk(acc_value == acc_exp, st ? "R7 accumulator kept" : "R6 loaded word",
        32'(acc_value), 32'(acc_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(acc_value == '0, "R1 accumulator zero", 32'(acc_value), 32'd0);
    chk(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 32'd1);
    chk(bank_ce == '0, "R1 no enable", 32'(bank_ce), 32'd0);
    chk(done == 1'b0, "R1 done low", 32'(done), 32'd0);

    // R2 idle with no request: nothing moves
    repeat (3) begin
      @(negedge clk);
      chk(bank_ce == '0 && done == 1'b0 && cmd_ready == 1'b1,
          "R2 idle quiet", {bank_ce, done, cmd_ready}, 32'd1);
    end

    // R7 store every word, R9 accumulator writes
    for (int a = 0; a < WORDS; a++) begin
      set_acc(pat(a));
      run_cmd(1'b1, a, 1'b0, pat(a));
    end

    // R6 load every word back, descending
    for (int a = WORDS - 1; a >= 0; a--) begin
      run_cmd(1'b0, a, 1'b0, pat(a));
    end

    // R10 bank boundaries and top address
    run_cmd(1'b0, 8'h3F, 1'b0, pat(8'h3F));
    run_cmd(1'b0, 8'h40, 1'b0, pat(8'h40));
    run_cmd(1'b0, 8'hBF, 1'b0, pat(8'hBF));
    run_cmd(1'b0, 8'hC0, 1'b0, pat(8'hC0));
    run_cmd(1'b0, 8'hFF, 1'b0, pat(8'hFF));

    // R3 activity during a load is ignored; target of the ignored store intact
    run_cmd(1'b0, 5, 1'b1, pat(5));
    run_cmd(1'b0, 5 ^ 8'hC3, 1'b0, pat(5 ^ 8'hC3));
    // R3 activity during a store is ignored
    set_acc(16'h0F0F);
    run_cmd(1'b1, 8'h41, 1'b1, 16'h0F0F);
    run_cmd(1'b0, 8'h41 ^ 8'hC3, 1'b0, pat(8'h41 ^ 8'hC3));
    run_cmd(1'b0, 8'h41, 1'b0, 16'h0F0F);

    // R9 accumulator write together with an accepted store
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_store = 1'b1;
    cmd_addr = 8'h80;
    acc_set_en = 1'b1;
    acc_set_data = 16'hBEEF;
    @(negedge clk);
    cmd_valid = 1'b0;
    acc_set_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(acc_value == 16'hBEEF, "R9 write with store", 32'(acc_value), 32'hBEEF);
    set_acc(16'h0000);
    run_cmd(1'b0, 8'h80, 1'b0, 16'hBEEF);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule